// File: doc/BRIEF.md
# Frequent value codec

This block keeps a small dictionary of 32-bit values that a cache uses often, and converts between those values and short codes. On the store side, an encoder compares a 32-bit operand against every entry at once. It returns a compressed flag and the position of the matching entry. On the read side, several independent decode ports each take a code and return the stored 32-bit value in the same cycle. A cache can then keep just the code and the flag for a word that matches an entry.

The dictionary has a single storage array, which serves both the encoder and the decoder. Because of this, a code produced on the store side always decodes back to the same value. The table is filled once, through a bulk-load port that writes one entry per cycle. After the expected number of entries, the block raises a ready flag. From then on the contents cannot change until reset, and the encoder reports matches only while that flag is high.

Top module: `fv_codec`

## Requirements
- R1: After reset, `ready` is low, `enc_hit` is low and `enc_code` is zero.
- R2: While `ready` is low, each cycle with `ld_valid` high stores `ld_value` into the entry selected by `ld_index`. That entry can be read on any decode port from the following cycle.
- R3: `ready` rises in the cycle after the ENTRIES-th accepted load write. It stays high until reset.
- R4: While `ready` is low, `enc_hit` is low and `enc_code` is zero, whatever the table holds.
- R5: While `ready` is high, `enc_hit` is high exactly when `enc_value` equals some entry. `enc_code` is then that entry's index, as an unsigned binary number of log2(ENTRIES) bits.
- R6: When several entries hold the encoded value, `enc_code` gives the lowest index among them.
- R7: Decode port k takes its code from bits [k*CW +: CW] of `dec_code` and returns the entry at that index on bits [k*32 +: 32] of `dec_value`. The result appears in the same cycle, and each port is independent of the others.
- R8: Once `ready` is high, `ld_valid` has no effect: every entry keeps its value.
- R9: When `enc_hit` is high, decoding `enc_code` returns `enc_value`.
- R10: When `enc_hit` is low, `enc_code` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Bulk-load write strobe |
| ld_index | input | CW | Entry index to load |
| ld_value | input | 32 | Value to load |
| ready | output | 1 | Table complete and frozen |
| enc_value | input | 32 | Operand to encode |
| enc_hit | output | 1 | Operand matches an entry |
| enc_code | output | CW | Index of the lowest matching entry |
| dec_code | input | RD_PORTS*CW | Packed codes, one per decode port |
| dec_value | output | RD_PORTS*32 | Packed decoded values |

## Verification
The bench uses the default eight entries (3-bit codes) and two decode ports. With that size, every code can be loaded in a scrambled order. Duplicated values at two positions exercise the lowest-index rule, and the two ports can be driven with different codes in the same cycle. Random operands drawn half from the table and half from the full 32-bit space give both matches and misses. Load writes attempted after `ready` check that the table stays frozen.

// File: rtl/fv_codec.sv
module fv_codec #(
  parameter int ENTRIES  = 8,
  parameter int RD_PORTS = 2,
  parameter int DW       = 32,
  localparam int CW      = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [CW-1:0]          ld_index,
  input  logic [DW-1:0]          ld_value,
  output logic                   ready,
  input  logic [DW-1:0]          enc_value,
  output logic                   enc_hit,
  output logic [CW-1:0]          enc_code,
  input  logic [RD_PORTS*CW-1:0] dec_code,
  output logic [RD_PORTS*DW-1:0] dec_value
);

  logic [DW-1:0] table_q [ENTRIES];
  logic [CW:0]   fill_q;
  logic          match_any;
  logic [CW-1:0] match_idx;

  wire load_en = ld_valid && !ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      ready  <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
    end else if (load_en) begin
      table_q[ld_index] <= ld_value;
      fill_q            <= fill_q + 1'b1;
      if (fill_q == (CW+1)'(ENTRIES - 1)) ready <= 1'b1;
    end
  end

  always_comb begin
    match_any = 1'b0;
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (table_q[i] == enc_value) begin
        match_any = 1'b1;
        match_idx = CW'(i);
      end
    end
  end

  assign enc_hit  = ready && match_any;
  assign enc_code = enc_hit ? match_idx : '0;

  for (genvar k = 0; k < RD_PORTS; k++) begin : g_rd
    assign dec_value[k*DW +: DW] = table_q[dec_code[k*CW +: CW]];
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ld_valid)); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready) && $stable(dec_code[CW-1:0])) |-> $stable(dec_value[DW-1:0])); // R8
  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_hit && dec_code[CW-1:0] == enc_code) |-> dec_value[DW-1:0] == enc_value); // R9
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_hit |-> enc_code == '0); // R10
  AST_NO_HIT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !enc_hit); // R4

endmodule

// File: tb/test_fv_codec.sv
module test_fv_codec;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int RD_PORTS = 2;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0, ld_valid = 0, ready, enc_hit;
  logic [CW-1:0] ld_index = 0, enc_code;
  logic [31:0] ld_value = 0, enc_value = 0;
  logic [RD_PORTS*CW-1:0] dec_code = 0;
  logic [RD_PORTS*32-1:0] dec_value;
  logic [31:0] model [ENTRIES];
  int compared = 0, mismatched = 0;

  fv_codec i_fv_codec (.clk, .rst_n, .ld_valid, .ld_index, .ld_value, .ready,
    .enc_value, .enc_hit, .enc_code, .dec_code, .dec_value);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [CW:0] exp_enc(logic [31:0] v, logic rdy);
    if (!rdy) return '0;
    for (int i = 0; i < ENTRIES; i++)
      if (model[i] == v) return {1'b1, CW'(i)};
    return '0;
  endfunction

  task automatic check_enc(string req, logic [31:0] v, logic rdy);
    logic [CW:0] e;
    enc_value = v;
    #1;
    e = exp_enc(v, rdy);
    chk(req, {31'b0, enc_hit}, {31'b0, e[CW]});
    chk(req, {29'b0, enc_code}, {29'b0, e[CW-1:0]});
  endtask

  task automatic check_dec(string req, int c0, int c1);
    dec_code = {CW'(c1), CW'(c0)};
    #1;
    chk(req, dec_value[31:0], model[c0]);
    chk(req, dec_value[63:32], model[c1]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int order [ENTRIES] = '{5, 2, 7, 0, 3, 6, 1, 4};
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) model[i] = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 ready", {31'b0, ready}, 0);
    check_enc("R1 enc", 32'h0, 1'b0);

    for (int i = 0; i < ENTRIES; i++) model[i] = 32'hA000_0000 + 32'(i * 17);
    model[5] = model[2];
    for (int j = 0; j < ENTRIES; j++) begin
      @(negedge clk);
      ld_valid = 1; ld_index = CW'(order[j]); ld_value = model[order[j]];
      @(negedge clk);
      ld_valid = 0;
      #1;
      chk("R3 ready timing", {31'b0, ready}, (j == ENTRIES-1) ? 32'd1 : 32'd0);
      if (j < ENTRIES-1) begin
        check_dec("R2 loaded entry", order[j], order[j]);
        check_enc("R4 no hit before ready", model[order[j]], 1'b0);
      end
    end

    check_enc("R6 lowest index on duplicate", model[2], 1'b1);
    chk("R6 code", {29'b0, enc_code}, 32'd2);
    check_enc("R10 miss code zero", 32'hDEAD_BEEF, 1'b1);
    check_dec("R7 two ports", 0, 7);

    for (int t = 0; t < 200; t++) begin
      logic [31:0] v;
      @(negedge clk);
      v = ($urandom % 2) ? model[$urandom % ENTRIES] : $urandom;
      check_enc("R5 random encode", v, 1'b1);
      if (enc_hit) begin
        dec_code = {CW'($urandom % ENTRIES), enc_code};
        #1;
        chk("R9 round trip", dec_value[31:0], v);
      end
      check_dec("R7 random decode", $urandom % ENTRIES, $urandom % ENTRIES);
    end

    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      ld_valid = 1; ld_index = CW'(j); ld_value = 32'h5555_0000 + 32'(j);
    end
    @(negedge clk); ld_valid = 0;
    for (int j = 0; j < ENTRIES; j++) check_dec("R8 frozen after ready", j, ENTRIES-1-j);
    chk("R3 ready held", {31'b0, ready}, 1);
    check_enc("R8 stray value not matched", 32'h5555_0000, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule